// File: doc/BRIEF.md
# Port-Group Housekeeping Decoder with Shared Edge Interrupt

This block sits in a 16-byte, byte-wide I/O window next to two parallel-port groups. It splits the window's low half into two 4-byte chip selects, one per group, and passes the selected group's read data back onto the bus. The high half holds a small set of housekeeping registers: two buffer-enable bits, a counter-addressing enable, an interrupt enable and an interrupt acknowledge.

Several of these registers act through the access itself, not through its data. Any write to the interrupt-enable offset turns interrupts on, and any read of that offset turns them off. The counter-addressing enable at its own offset works the same way. A write of any value to the acknowledge offset drops the shared request.

Two interrupt sources exist: bit 3 of port C in each group. Each is synchronised, and its rising edges are detected. While interrupts are enabled, an edge on either source sets one pending latch. That latch drives the single request output until software acknowledges it. Software should acknowledge first and then enable, so that a stale pending flag cannot fire.

Top module: `iowin_ctrl_dec`

## Requirements
- R1: After a synchronous reset with rst_n low, buf_en is 2'b00, cnt_addr_en is 0, irq_req is 0 and interrupts are disabled.
- R2: An access (rd or wr) at offsets 0x0–0x3 raises grp_cs[0] only, and one at 0x4–0x7 raises grp_cs[1] only. A read there returns grp0_rdata or grp1_rdata unchanged. With no access, or at offsets 0x8–0xF, grp_cs is 2'b00.
- R3: A write to 0x8 stores wdata bit 0 into buf_en[0], and a write to 0x9 stores it into buf_en[1]. A read of either offset returns {7'b0, stored bit}.
- R4: A write of any data to 0xD sets cnt_addr_en on the next clock. A read of 0xD with no write clears it on the next clock.
- R5: A write of any data to 0xB enables interrupts, and a read of 0xB disables them. After that read, rising edges are not latched.
- R6: While interrupts are enabled, a rising edge on bit 3 of grp0_portc or grp1_portc sets irq_req within 4 clocks, counted from the first clock that samples the new level.
- R7: A rising edge that arrives while interrupts are disabled leaves irq_req at 0, even after interrupts are enabled later.
- R8: A write of any data to 0xF clears irq_req. If a new qualified edge is detected in the same cycle as that write, irq_req stays 1.
- R9: Once set, irq_req holds until a write to 0xF. A falling source or a disable read does not clear it.
- R10: Falling edges, and changes on port C bits other than bit 3, never set irq_req.
- R11: Reads of 0xA, 0xC, 0xE and 0xF return 8'h00. Accesses to 0xA, 0xC and 0xE change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, combinational |
| grp_cs | output | 2 | Chip select per port group sub-window |
| grp0_rdata | input | 8 | Read data from group 0 |
| grp1_rdata | input | 8 | Read data from group 1 |
| grp0_portc | input | 8 | Port C pins of group 0 (bit 3 is the source) |
| grp1_portc | input | 8 | Port C pins of group 1 (bit 3 is the source) |
| buf_en | output | 2 | Buffer enable per group, 1 = drive |
| cnt_addr_en | output | 1 | Counter/timer addressing enable |
| irq_req | output | 1 | Shared interrupt request |

## Verification
The checker watches every cycle for these properties:
- the chip selects are one-hot and follow the address;
- the buffer bits load from write data;
- the counter enable responds to writes and reads at its offset;
- unused offsets read as zero;
- a set request never drops except on an acknowledge write.

Only the bench scenarios can show three behaviours, because each depends on hidden state or on exact pipeline timing:
- the interrupt enable gates edges;
- a read of 0xB disables further latching;
- an edge detected in the same cycle as an acknowledge wins.

// File: rtl/iowin_pkg.sv
// Package: shared offsets and decoded-access type for the I/O window decoder.
// Assumes a 16-byte window with 8-bit data.
package iowin_pkg;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam logic [AW-1:0] OFF_BUF0 = 4'h8;
    localparam logic [AW-1:0] OFF_BUF1 = 4'h9;
    localparam logic [AW-1:0] OFF_IEN  = 4'hB;
    localparam logic [AW-1:0] OFF_CEN  = 4'hD;
    localparam logic [AW-1:0] OFF_ACK  = 4'hF;

    typedef struct packed {
        logic       buf0_wr;
        logic       buf1_wr;
        logic       ien_set;
        logic       ien_clr;
        logic       cen_set;
        logic       cen_clr;
        logic       ack;
        logic [1:0] cs;
    } acc_t;
endpackage

// File: rtl/iowin_decode.sv
// Module: iowin_decode
// Turns one bus access into per-register strobes and group chip selects.
// Assumes rd and wr are single-cycle and are not both high at once.
module iowin_decode
    import iowin_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output acc_t          acc
);
    logic any;

    // Decode offset and strobe into side-effect pulses.
    always_comb begin
        any          = rd | wr;
        acc.buf0_wr  = wr && (addr == OFF_BUF0);
        acc.buf1_wr  = wr && (addr == OFF_BUF1);
        acc.ien_set  = wr && (addr == OFF_IEN);
        acc.ien_clr  = rd && !wr && (addr == OFF_IEN);
        acc.cen_set  = wr && (addr == OFF_CEN);
        acc.cen_clr  = rd && !wr && (addr == OFF_CEN);
        acc.ack      = wr && (addr == OFF_ACK);
        acc.cs[0]    = any && (addr[3:2] == 2'b00);
        acc.cs[1]    = any && (addr[3:2] == 2'b01);
    end
endmodule

// File: rtl/iowin_edge_sync.sv
// Module: iowin_edge_sync
// Synchronises one asynchronous line through STAGES flops and pulses rise
// for one cycle on each low-to-high change. Assumes STAGES >= 2.
module iowin_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int W = STAGES + 1;
    logic [W-1:0] sh;

    // Shift the line through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[W-2:0], din};
    end

    // Rising edge: newest synchronised sample high, previous low.
    assign rise = sh[W-2] & ~sh[W-1];
endmodule

// File: rtl/iowin_irq_latch.sv
// Module: iowin_irq_latch
// Holds the interrupt enable and one pending flag shared by NSRC sources.
// A qualified edge outranks a same-cycle acknowledge.
module iowin_irq_latch #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_set,
    input  logic            en_clr,
    input  logic            ack,
    input  logic [NSRC-1:0] rise,
    output logic            pending
);
    logic enabled;

    // Enable flag: write sets it, read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      enabled <= 1'b0;
        else if (en_set) enabled <= 1'b1;
        else if (en_clr) enabled <= 1'b0;
    end

    // Pending latch: an enabled edge sets it first, then acknowledge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pending <= 1'b0;
        else if (enabled && (|rise))      pending <= 1'b1;
        else if (ack)                     pending <= 1'b0;
    end
endmodule

// File: rtl/iowin_ctrl_dec.sv
// Module: iowin_ctrl_dec (top)
// Housekeeping decoder for a 16-byte window beside two port groups:
// chip selects, buffer enables, counter-addressing enable and a shared
// rising-edge interrupt from port C bit TAP_BIT of each group.
// Assumes a synchronous bus with single-cycle rd/wr strobes.
module iowin_ctrl_dec
    import iowin_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TAP_BIT     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    input  logic          bus_wr,
    output logic [DW-1:0] bus_rdata,
    output logic [1:0]    grp_cs,
    input  logic [DW-1:0] grp0_rdata,
    input  logic [DW-1:0] grp1_rdata,
    input  logic [DW-1:0] grp0_portc,
    input  logic [DW-1:0] grp1_portc,
    output logic [1:0]    buf_en,
    output logic          cnt_addr_en,
    output logic          irq_req
);
    localparam int NGRP = 2;

    acc_t            acc;
    logic [NGRP-1:0] src;
    logic [NGRP-1:0] rise;

    iowin_decode u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .acc  (acc)
    );

    assign src    = {grp1_portc[TAP_BIT], grp0_portc[TAP_BIT]};
    assign grp_cs = acc.cs;

    for (genvar g = 0; g < NGRP; g++) begin : g_src
        iowin_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (src[g]),
            .rise  (rise[g])
        );
    end

    iowin_irq_latch #(.NSRC(NGRP)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (acc.ien_set),
        .en_clr  (acc.ien_clr),
        .ack     (acc.ack),
        .rise    (rise),
        .pending (irq_req)
    );

    // Buffer-enable bits: store write-data bit 0 per group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_en <= 2'b00;
        end else begin
            if (acc.buf0_wr) buf_en[0] <= bus_wdata[0];
            if (acc.buf1_wr) buf_en[1] <= bus_wdata[0];
        end
    end

    // Counter-addressing enable: write sets it, read clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_addr_en <= 1'b0;
        else if (acc.cen_set) cnt_addr_en <= 1'b1;
        else if (acc.cen_clr) cnt_addr_en <= 1'b0;
    end

    // Read mux: group data, buffer bits, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (acc.cs[0])                 bus_rdata = grp0_rdata;
            else if (acc.cs[1])            bus_rdata = grp1_rdata;
            else if (bus_addr == OFF_BUF0) bus_rdata = {{(DW-1){1'b0}}, buf_en[0]};
            else if (bus_addr == OFF_BUF1) bus_rdata = {{(DW-1){1'b0}}, buf_en[1]};
        end
    end
endmodule

// File: rtl/iowin_ctrl_dec_chk.sv
// Module: iowin_ctrl_dec_chk
// Port-level assertions for iowin_ctrl_dec, attached with bind.
module iowin_ctrl_dec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic [1:0] grp_cs,
    input logic [1:0] buf_en,
    input logic       cnt_addr_en,
    input logic       irq_req
);
    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_cs));
    // R2
    cs_grp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_addr[3:2] == 2'b00) |-> grp_cs == 2'b01);
    // R2
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |-> grp_cs == 2'b00);
    // R3
    buf0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h8) |=> buf_en[0] == $past(bus_wdata[0]));
    // R4
    cen_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'hD) |=> cnt_addr_en);
    // R4
    cen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 4'hD) |=> !cnt_addr_en);
    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !(bus_wr && bus_addr == 4'hF)) |=> irq_req);
    // R11
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 4'hA || bus_addr == 4'hC ||
                    bus_addr == 4'hE || bus_addr == 4'hF)) |-> bus_rdata == 8'h00);
endmodule

bind iowin_ctrl_dec iowin_ctrl_dec_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .grp_cs      (grp_cs),
    .buf_en      (buf_en),
    .cnt_addr_en (cnt_addr_en),
    .irq_req     (irq_req)
);

// File: tb/sim_iowin_ctrl_dec.sv
// Directed bench for iowin_ctrl_dec: one task per scenario.
module sim_iowin_ctrl_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_rdata;
    logic [1:0] grp_cs;
    logic [7:0] grp0_rdata = 8'hA5;
    logic [7:0] grp1_rdata = 8'h3C;
    logic [7:0] grp0_portc = '0;
    logic [7:0] grp1_portc = '0;
    logic [1:0] buf_en;
    logic       cnt_addr_en;
    logic       irq_req;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    iowin_ctrl_dec u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 buf_en", buf_en, 0);
        chk("R1 cnt_addr_en", cnt_addr_en, 0);
        chk("R1 irq_req", irq_req, 0);
        grp0_portc[3] = 1'b1; idle(6);
        chk("R1 irq disabled", irq_req, 0);
        grp0_portc[3] = 1'b0; idle(4);
    endtask

    task automatic t_cs;
        logic [7:0] d;
        @(negedge clk); bus_addr = 4'h2; bus_rd = 1'b1; #1;
        chk("R2 cs grp0", grp_cs, 2'b01);
        chk("R2 rdata grp0", bus_rdata, 8'hA5);
        bus_addr = 4'h7; #1;
        chk("R2 cs grp1", grp_cs, 2'b10);
        chk("R2 rdata grp1", bus_rdata, 8'h3C);
        bus_addr = 4'h9; #1;
        chk("R2 cs high half", grp_cs, 2'b00);
        @(negedge clk); bus_rd = 1'b0; bus_addr = 4'h1; #1;
        chk("R2 cs idle", grp_cs, 2'b00);
        bus_read(4'h4, d);
        chk("R2 read grp1", d, 8'h3C);
    endtask

    task automatic t_buf;
        logic [7:0] d;
        bus_write(4'h8, 8'hFF);
        chk("R3 buf0 set", buf_en, 2'b01);
        bus_write(4'h9, 8'h01);
        chk("R3 buf1 set", buf_en, 2'b11);
        bus_read(4'h9, d);
        chk("R3 readback", d, 8'h01);
        bus_write(4'h8, 8'hFE);
        chk("R3 buf0 clr by bit0", buf_en, 2'b10);
        bus_read(4'h8, d);
        chk("R3 readback0", d, 8'h00);
    endtask

    task automatic t_cnt;
        bus_write(4'hD, 8'h00);
        chk("R4 write sets", cnt_addr_en, 1);
        bus_write(4'hD, 8'h5A);
        chk("R4 still set", cnt_addr_en, 1);
        begin logic [7:0] d; bus_read(4'hD, d); end
        chk("R4 read clears", cnt_addr_en, 0);
    endtask

    task automatic t_irq_basic;
        bus_write(4'hF, 8'h00);
        bus_write(4'hB, 8'h00);
        grp0_portc[3] = 1'b1; idle(5);
        chk("R6 grp0 edge", irq_req, 1);
        grp0_portc[3] = 1'b0; idle(5);
        chk("R9 holds after fall", irq_req, 1);
        bus_write(4'hF, 8'h77);
        chk("R8 ack clears", irq_req, 0);
        grp1_portc[3] = 1'b1; idle(5);
        chk("R6 grp1 edge", irq_req, 1);
        grp1_portc[3] = 1'b0;
        begin logic [7:0] d; bus_read(4'hB, d); end
        chk("R9 disable keeps pending", irq_req, 1);
        bus_write(4'hF, 8'h00); idle(4);
    endtask

    task automatic t_read_disable;
        logic [7:0] d;
        bus_write(4'hB, 8'h00);
        bus_read(4'hB, d);
        grp0_portc[3] = 1'b1; idle(6);
        chk("R5 read disables", irq_req, 0);
        grp0_portc[3] = 1'b0; idle(4);
    endtask

    task automatic t_disabled_edge;
        grp1_portc[3] = 1'b1; idle(6);
        bus_write(4'hB, 8'h00); idle(4);
        chk("R7 stale edge", irq_req, 0);
        grp1_portc[3] = 1'b0; idle(4);
        chk("R10 fall ignored", irq_req, 0);
    endtask

    task automatic t_other_bits;
        grp0_portc = 8'hF7; grp1_portc = 8'hF7; idle(6);
        chk("R10 other bits", irq_req, 0);
        grp0_portc = 8'h00; grp1_portc = 8'h00; idle(5);
        chk("R10 other bits fall", irq_req, 0);
    endtask

    task automatic t_race;
        grp0_portc[3] = 1'b1; idle(5);
        chk("R6 prep pending", irq_req, 1);
        @(negedge clk); grp1_portc[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk); bus_addr = 4'hF; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        chk("R8 edge beats ack", irq_req, 1);
        bus_write(4'hF, 8'h00);
        chk("R8 later ack", irq_req, 0);
        grp0_portc[3] = 1'b0; grp1_portc[3] = 1'b0;
        begin logic [7:0] d; bus_read(4'hB, d); end
        idle(4);
    endtask

    task automatic t_unused;
        logic [7:0] d;
        bus_write(4'hA, 8'hFF); bus_write(4'hC, 8'hFF); bus_write(4'hE, 8'hFF);
        chk("R11 no effect buf", buf_en, 2'b10);
        chk("R11 no effect cnt", cnt_addr_en, 0);
        chk("R11 no effect irq", irq_req, 0);
        bus_read(4'hA, d); chk("R11 read A", d, 0);
        bus_read(4'hC, d); chk("R11 read C", d, 0);
        bus_read(4'hE, d); chk("R11 read E", d, 0);
        bus_read(4'hF, d); chk("R11 read F", d, 0);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_cs();
        t_buf();
        t_cnt();
        t_irq_basic();
        t_read_disable();
        t_disabled_edge();
        t_other_bits();
        bus_write(4'hF, 8'h00);
        t_race();
        t_unused();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule